// File: doc/BRIEF.md
# SD Video EDH Packet Checker

The checker sits on a 10-bit standard-definition serial digital video word stream and judges each field against the error detection and handling (EDH) packet carried in it. It computes two local CRCs, one over the active picture and one over the full field, and compares them with the values the packet carries. It also checks the checksum of every other ancillary packet in the field. Separately, it keeps exact copies of the three 5-bit flag groups found in the packet. It never alters the stream: it only reports.

Position qualifiers come from an upstream timing decoder. `field_start` marks the first word of a field, and `ap_en` and `ff_en` mark the words that belong to the active-picture and full-field CRC regions. These enables must be low during ancillary packets. A packet parser is built as a state machine with states IDLE, ADF1, ADF2, DID, SDID, DC, UDW and CS. A valid word of 0x000 moves IDLE→ADF1. 0x3FF moves ADF1→ADF2 and ADF2→DID; any other word returns to IDLE, except that 0x000 keeps ADF1. Each valid word then steps DID→SDID→DC. DC goes to UDW, or straight to CS when the count is zero. UDW stays in UDW until the last user word and then goes to CS. CS always returns to IDLE. All per-field results are registered on the clock edge that takes the EDH packet's checksum word, and they hold until the next EDH packet.

The EDH payload layout used here is as follows. User word 0 carries the active-picture CRC bits 7:0, word 1 bits 15:8, and words 2 and 3 the full-field CRC the same way. Words 4, 5 and 6 carry the ancillary, full-field and active-picture flag groups in bits 4:0. Words 7 to 15 are reserved.

Top module: `edh_checker`

## Requirements
- R1: After reset every output is zero.
- R2: `ap_err` is set when the CRC-16 (x^16+x^12+x^5+1, zero start, data bits 9:2 of each word with `ap_en` high, most significant bit first) differs from the value in user words 0 and 1 of the EDH packet, low byte first.
- R3: `ff_err` follows the same rule for words with `ff_en` high against user words 2 and 3.
- R4: `anc_err` is set when any ancillary packet whose DID low byte is not 0xF4, ending earlier in the same field, had a bad checksum. The checksum word must satisfy bits 8:0 = 9-bit sum of bits 8:0 of DID through the last user word, and bit 9 = inverse of bit 8.
- R5: `anc_flags`, `ff_flags` and `ap_flags` copy bits 4:0 of EDH user words 4, 5 and 6. In each group, bit0 is EDH, bit1 EDA, bit2 IDH, bit3 IDA and bit4 UES.
- R6: `pkt_flags[1]` is set when any EDH user word has bit 8 different from the XOR of bits 7:0, or bit 9 equal to bit 8.
- R7: `pkt_flags[2]` is set when the EDH packet's own checksum word fails the rule in R4. A bad checksum on a packet that is not EDH leaves it clear.
- R8: `pkt_flags[3]` is set when the EDH data count is not 16. In that case `ap_err`, `ff_err`, `anc_err` and the three flag groups keep their previous values.
- R9: `pkt_flags[0]` is set at a `field_start` word when the field just ended, following at least one earlier `field_start`, held no EDH packet. It is cleared when the next EDH packet ends.
- R10: `anc_err`, `ap_err`, `ff_err` and the flag groups change only on the EDH checksum word. `pkt_flags` changes only there or at `field_start`.
- R11: An EDH packet is recognised only after the valid sequence 0x000, 0x3FF, 0x3FF followed by a DID word whose low byte is 0xF4.
- R12: Both CRCs restart from zero at each `field_start` word. That word is included when its enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_word | input | 10 | Video word |
| vid_valid | input | 1 | Word valid strobe |
| field_start | input | 1 | First word of a field (qualified by vid_valid) |
| ap_en | input | 1 | Word lies in the active-picture CRC region |
| ff_en | input | 1 | Word lies in the full-field CRC region |
| anc_err | output | 1 | Ancillary checksum failure seen this field |
| ap_err | output | 1 | Active-picture CRC mismatch |
| ff_err | output | 1 | Full-field CRC mismatch |
| anc_flags | output | 5 | Received ancillary flag group |
| ff_flags | output | 5 | Received full-field flag group |
| ap_flags | output | 5 | Received active-picture flag group |
| pkt_flags | output | 4 | bit0 missing, bit1 parity, bit2 checksum, bit3 format |

## Verification
A parser that loses its place misreads the packet at its very next checksum word. It then shows wrong copied flags, or a spurious checksum or format flag, within one field. A CRC that fails to restart stays wrong for every later field, so a clean field that follows a corrupted one exposes it at once. A stale ancillary or seen-packet record shows up one field late, as a false `anc_err` or a missing `pkt_flags[0]` at the next boundary.

// File: rtl/edh_chk_pkg.sv
package edh_chk_pkg;
    localparam int WORD_W = 10;
    localparam int CRC_W  = 16;
    localparam int FLAG_W = 5;

    typedef enum logic [2:0] {
        S_IDLE, S_ADF1, S_ADF2, S_DID, S_SDID, S_DC, S_UDW, S_CS
    } pstate_t;

    typedef struct packed {
        logic [CRC_W-1:0]  ap_crc;
        logic [CRC_W-1:0]  ff_crc;
        logic [FLAG_W-1:0] anc_fl;
        logic [FLAG_W-1:0] ff_fl;
        logic [FLAG_W-1:0] ap_fl;
    } edh_fields_t;
endpackage

// File: rtl/edh_crc_acc.sv
module edh_crc_acc #(
    parameter int          DBITS = 8,
    parameter logic [15:0] POLY  = 16'h1021
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic [DBITS-1:0] data,
    output logic [15:0]      crc
);
    function automatic logic [15:0] crc_step(input logic [15:0] c_in, input logic [DBITS-1:0] d);
        logic [15:0] c;
        logic        fb;
        c = c_in;
        for (int i = DBITS - 1; i >= 0; i--) begin
            fb = c[15] ^ d[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ POLY;
        end
        return c;
    endfunction

    logic [15:0] base, nxt;

    always_comb begin
        base = clear ? 16'h0000 : crc;
        nxt  = en ? crc_step(base, data) : base;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc <= 16'h0000;
        else        crc <= nxt;
    end

    // R12: a field start with no enabled word leaves a zero CRC
    p_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !en) |=> (crc == 16'h0000));
endmodule

// File: rtl/edh_pkt_parser.sv
module edh_pkt_parser
    import edh_chk_pkg::*;
#(
    parameter logic [7:0] EDH_DID = 8'hF4,
    parameter int         EDH_DC  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    input  logic              valid,
    output logic              done,
    output logic              is_edh,
    output logic              cs_ok,
    output logic              par_bad,
    output logic              dc_bad,
    output edh_fields_t       fields
);
    localparam int CNT_W = 8;

    pstate_t           state, nxt;
    logic [8:0]        sum;
    logic [CNT_W-1:0]  cnt, idx, dc_r;
    logic              is_edh_r, par_r;
    edh_fields_t       fld_r;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)     state <= S_IDLE;
        else if (valid) state <= nxt;
    end

    // next state
    always_comb begin
        nxt = S_IDLE;
        unique case (state)
            S_IDLE:  nxt = (word == 10'h000) ? S_ADF1 : S_IDLE;
            S_ADF1:  nxt = (word == 10'h3FF) ? S_ADF2 : ((word == 10'h000) ? S_ADF1 : S_IDLE);
            S_ADF2:  nxt = (word == 10'h3FF) ? S_DID : S_IDLE;
            S_DID:   nxt = S_SDID;
            S_SDID:  nxt = S_DC;
            S_DC:    nxt = (word[7:0] == '0) ? S_CS : S_UDW;
            S_UDW:   nxt = (cnt == CNT_W'(1)) ? S_CS : S_UDW;
            S_CS:    nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // packet data path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum <= '0; cnt <= '0; idx <= '0; dc_r <= '0;
            is_edh_r <= 1'b0; par_r <= 1'b0; fld_r <= '0;
        end else if (valid) begin
            unique case (state)
                S_DID: begin
                    is_edh_r <= (word[7:0] == EDH_DID);
                    sum      <= word[8:0];
                    par_r    <= 1'b0;
                end
                S_SDID: sum <= sum + word[8:0];
                S_DC: begin
                    sum  <= sum + word[8:0];
                    cnt  <= word[7:0];
                    dc_r <= word[7:0];
                    idx  <= '0;
                end
                S_UDW: begin
                    sum <= sum + word[8:0];
                    cnt <= cnt - CNT_W'(1);
                    idx <= idx + CNT_W'(1);
                    if (is_edh_r) begin
                        if ((word[8] != ^word[7:0]) || (word[9] == word[8])) par_r <= 1'b1;
                        case (idx)
                            8'd0: fld_r.ap_crc[7:0]  <= word[7:0];
                            8'd1: fld_r.ap_crc[15:8] <= word[7:0];
                            8'd2: fld_r.ff_crc[7:0]  <= word[7:0];
                            8'd3: fld_r.ff_crc[15:8] <= word[7:0];
                            8'd4: fld_r.anc_fl       <= word[4:0];
                            8'd5: fld_r.ff_fl        <= word[4:0];
                            8'd6: fld_r.ap_fl        <= word[4:0];
                            default: ;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        done    = valid && (state == S_CS);
        is_edh  = is_edh_r;
        cs_ok   = (word[8:0] == sum) && (word[9] == ~word[8]);
        par_bad = par_r;
        dc_bad  = (dc_r != CNT_W'(EDH_DC));
        fields  = fld_r;
    end

    // R11: the DID state is entered only from the second 3FF of the flag
    p_did_after_adf_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DID) |-> ($past(state) == S_ADF2));
endmodule

// File: rtl/edh_checker.sv
module edh_checker
    import edh_chk_pkg::*;
#(
    parameter logic [7:0]  EDH_DID  = 8'hF4,
    parameter int          EDH_DC   = 16,
    parameter logic [15:0] CRC_POLY = 16'h1021
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] vid_word,
    input  logic              vid_valid,
    input  logic              field_start,
    input  logic              ap_en,
    input  logic              ff_en,
    output logic              anc_err,
    output logic              ap_err,
    output logic              ff_err,
    output logic [FLAG_W-1:0] anc_flags,
    output logic [FLAG_W-1:0] ff_flags,
    output logic [FLAG_W-1:0] ap_flags,
    output logic [3:0]        pkt_flags
);
    localparam int DBITS = WORD_W - 2;

    logic        fs_w, done, is_edh, cs_ok, par_bad, dc_bad;
    logic        edh_done, anc_done;
    logic [15:0] ap_crc, ff_crc;
    edh_fields_t fields;
    logic        anc_acc, seen_pkt, started;

    assign fs_w = vid_valid && field_start;

    edh_crc_acc #(.DBITS(DBITS), .POLY(CRC_POLY)) u_ap_crc (
        .clk(clk), .rst_n(rst_n), .clear(fs_w), .en(vid_valid && ap_en),
        .data(vid_word[WORD_W-1:2]), .crc(ap_crc));

    edh_crc_acc #(.DBITS(DBITS), .POLY(CRC_POLY)) u_ff_crc (
        .clk(clk), .rst_n(rst_n), .clear(fs_w), .en(vid_valid && ff_en),
        .data(vid_word[WORD_W-1:2]), .crc(ff_crc));

    edh_pkt_parser #(.EDH_DID(EDH_DID), .EDH_DC(EDH_DC)) u_parser (
        .clk(clk), .rst_n(rst_n), .word(vid_word), .valid(vid_valid),
        .done(done), .is_edh(is_edh), .cs_ok(cs_ok), .par_bad(par_bad),
        .dc_bad(dc_bad), .fields(fields));

    assign edh_done = done && is_edh;
    assign anc_done = done && !is_edh;

    // per-field outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            anc_err <= 1'b0; ap_err <= 1'b0; ff_err <= 1'b0;
            anc_flags <= '0; ff_flags <= '0; ap_flags <= '0; pkt_flags <= '0;
            anc_acc <= 1'b0; seen_pkt <= 1'b0; started <= 1'b0;
        end else begin
            if (fs_w) begin
                anc_acc  <= 1'b0;
                seen_pkt <= 1'b0;
                started  <= 1'b1;
                if (started && !seen_pkt) pkt_flags[0] <= 1'b1;
            end
            if (anc_done && !cs_ok) anc_acc <= 1'b1;
            if (edh_done) begin
                seen_pkt  <= 1'b1;
                pkt_flags <= {dc_bad, !cs_ok, par_bad, 1'b0};
                if (!dc_bad) begin
                    ap_err    <= (fields.ap_crc != ap_crc);
                    ff_err    <= (fields.ff_crc != ff_crc);
                    anc_err   <= anc_acc;
                    anc_flags <= fields.anc_fl;
                    ff_flags  <= fields.ff_fl;
                    ap_flags  <= fields.ap_fl;
                end
            end
        end
    end

    // R10: field results move only on an EDH checksum word
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !edh_done |=> $stable({anc_err, ap_err, ff_err, anc_flags, ff_flags, ap_flags}));

    // R10: packet flags move only on an EDH checksum word or a field start
    p_pkt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(edh_done || fs_w) |=> $stable(pkt_flags));

    // R9: a received EDH packet clears the missing flag
    p_found_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        edh_done |=> !pkt_flags[0]);

    // R8: a bad data count freezes the comparison results
    p_format_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (edh_done && dc_bad) |=> (pkt_flags[3] && $stable(ap_err) && $stable(ap_flags)));
endmodule

// File: tb/edh_checker_test.sv
`timescale 1ns/1ps
module edh_checker_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] vid_word = '0;
    logic       vid_valid = 1'b0, field_start = 1'b0, ap_en = 1'b0, ff_en = 1'b0;
    logic       anc_err, ap_err, ff_err;
    logic [4:0] anc_flags, ff_flags, ap_flags;
    logic [3:0] pkt_flags;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    edh_checker uut (
        .clk(clk), .rst_n(rst_n), .vid_word(vid_word), .vid_valid(vid_valid),
        .field_start(field_start), .ap_en(ap_en), .ff_en(ff_en),
        .anc_err(anc_err), .ap_err(ap_err), .ff_err(ff_err),
        .anc_flags(anc_flags), .ff_flags(ff_flags), .ap_flags(ap_flags),
        .pkt_flags(pkt_flags));

    // {anc_bad, ap_bad, ff_bad, par_bad, cs_bad, seed[2:0], anc_fl, ff_fl, ap_fl}
    localparam logic [22:0] VEC [8] = '{
        {5'b00000, 3'd1, 5'b00000, 5'b00000, 5'b00000},
        {5'b01000, 3'd2, 5'b00001, 5'b00010, 5'b00100},
        {5'b00100, 3'd3, 5'b10000, 5'b01000, 5'b00011},
        {5'b10000, 3'd4, 5'b11111, 5'b00000, 5'b10101},
        {5'b00010, 3'd5, 5'b01010, 5'b10101, 5'b11111},
        {5'b00001, 3'd6, 5'b00110, 5'b11001, 5'b01100},
        {5'b11100, 3'd7, 5'b11100, 5'b00111, 5'b10010},
        {5'b00000, 3'd0, 5'b00000, 5'b00000, 5'b00000}
    };

    function automatic logic [15:0] crc8(input logic [15:0] c_in, input logic [7:0] d);
        logic [15:0] c = c_in;
        for (int i = 7; i >= 0; i--) begin
            logic fb = c[15] ^ d[i];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    function automatic logic [9:0] udw(input logic [7:0] b);
        return {~(^b), ^b, b};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [9:0] w, input logic fs, input logic ap, input logic ff);
        @(negedge clk);
        vid_word = w; vid_valid = 1'b1; field_start = fs; ap_en = ap; ff_en = ff;
    endtask

    task automatic idle();
        @(negedge clk);
        vid_valid = 1'b0; field_start = 1'b0; ap_en = 1'b0; ff_en = 1'b0; vid_word = 10'h200;
    endtask

    task automatic run_field(input logic [22:0] v, input bit send_edh, input logic [7:0] dc);
        logic [15:0] apc = '0, ffc = '0;
        logic [8:0]  s;
        logic [9:0]  w, cs;
        logic [7:0]  p;
        for (int i = 0; i < 24; i++) begin
            logic a = (i >= 6 && i < 18);
            w = {2'b01, 8'(v[17:15] * 29 + i * 37 + 5)};
            if (a) apc = crc8(apc, w[9:2]);
            ffc = crc8(ffc, w[9:2]);
            put(w, i == 0, a, 1'b1);
        end
        // ordinary ancillary packet
        put(10'h000, 0, 0, 0); put(10'h3FF, 0, 0, 0); put(10'h3FF, 0, 0, 0);
        s = '0;
        w = udw(8'h45); s = s + w[8:0]; put(w, 0, 0, 0);
        w = udw(8'h01); s = s + w[8:0]; put(w, 0, 0, 0);
        w = udw(8'h02); s = s + w[8:0]; put(w, 0, 0, 0);
        w = udw(8'h33); s = s + w[8:0]; put(w, 0, 0, 0);
        w = udw(8'h7C); s = s + w[8:0]; put(w, 0, 0, 0);
        cs = {~s[8], s} ^ (v[22] ? 10'h001 : 10'h000);
        put(cs, 0, 0, 0);
        if (v[21]) apc = apc ^ 16'h0100;
        if (v[20]) ffc = ffc ^ 16'h0001;
        if (send_edh) begin
            put(10'h000, 0, 0, 0); put(10'h3FF, 0, 0, 0); put(10'h3FF, 0, 0, 0);
            s = '0;
            w = udw(8'hF4); s = s + w[8:0]; put(w, 0, 0, 0);
            w = udw(8'h00); s = s + w[8:0]; put(w, 0, 0, 0);
            w = udw(dc);    s = s + w[8:0]; put(w, 0, 0, 0);
            for (int k = 0; k < int'(dc); k++) begin
                case (k)
                    0: p = apc[7:0];
                    1: p = apc[15:8];
                    2: p = ffc[7:0];
                    3: p = ffc[15:8];
                    4: p = {3'b000, v[14:10]};
                    5: p = {3'b000, v[9:5]};
                    6: p = {3'b000, v[4:0]};
                    default: p = 8'(k * 11);
                endcase
                w = udw(p);
                if (v[19] && k == 10) w = w ^ 10'h100;
                s = s + w[8:0];
                put(w, 0, 0, 0);
            end
            cs = {~s[8], s} ^ (v[18] ? 10'h001 : 10'h000);
            put(cs, 0, 0, 0);
        end
        put(10'h200, 0, 0, 0);
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [22:0] v;
        repeat (4) @(negedge clk);
        check("R1 reset errors", {13'd0, anc_err, ap_err, ff_err}, 16'd0);
        check("R1 reset flags", {1'b0, anc_flags, ff_flags, ap_flags}, 16'd0);
        check("R1 reset pkt_flags", {12'd0, pkt_flags}, 16'd0);
        rst_n = 1'b1;
        idle();

        for (int r = 0; r < 8; r++) begin
            v = VEC[r];
            run_field(v, 1'b1, 8'd16);
            check($sformatf("R4 anc_err row %0d", r), {15'd0, anc_err}, {15'd0, v[22]});
            check($sformatf("R2 R12 ap_err row %0d", r), {15'd0, ap_err}, {15'd0, v[21]});
            check($sformatf("R3 R12 ff_err row %0d", r), {15'd0, ff_err}, {15'd0, v[20]});
            check($sformatf("R5 flags row %0d", r), {1'b0, anc_flags, ff_flags, ap_flags}, {1'b0, v[14:0]});
            check($sformatf("R6 R7 R11 pkt_flags row %0d", r), {12'd0, pkt_flags},
                  {12'd0, 1'b0, v[18], v[19], 1'b0});
        end

        // R9/R10: field with no EDH packet holds results, boundary flags missing
        run_field(VEC[1], 1'b1, 8'd16);
        run_field(VEC[0], 1'b0, 8'd16);
        check("R10 held ap_err", {15'd0, ap_err}, 16'd1);
        check("R10 held flags", {1'b0, anc_flags, ff_flags, ap_flags}, {1'b0, VEC[1][14:0]});
        check("R10 pkt_flags before boundary", {12'd0, pkt_flags}, 16'd0);
        put(10'h180, 1, 0, 0);
        idle();
        check("R9 missing set", {12'd0, pkt_flags}, 16'h0001);
        run_field(VEC[0], 1'b1, 8'd16);
        check("R9 missing cleared", {12'd0, pkt_flags}, 16'h0000);
        check("R9 results after recovery", {13'd0, anc_err, ap_err, ff_err}, 16'd0);

        // R8: short data count
        run_field(VEC[1], 1'b1, 8'd16);
        run_field(VEC[0], 1'b1, 8'd15);
        check("R8 format flag", {12'd0, pkt_flags}, 16'h0008);
        check("R8 ap_err held", {15'd0, ap_err}, 16'd1);
        check("R8 flags held", {1'b0, anc_flags, ff_flags, ap_flags}, {1'b0, VEC[1][14:0]});
        run_field(VEC[0], 1'b1, 8'd16);
        check("R8 clean after format fault", {9'd0, ap_err, ff_err, anc_err, pkt_flags}, 16'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule